// File: doc/BRIEF.md
# Cascaded Fall-Through FIFO Depth Chain

This block builds one deep first-in first-out buffer out of a series of small fall-through buffer stages. Each stage presents its oldest word at its output together with a valid flag, with no read request needed. The output of each stage feeds the input of the next. A word moves from one stage to the next on any clock edge where the upstream stage holds a word and the downstream stage has a free slot. The link between stages is only this valid/ready handshake, with no other logic.

One clock drives every stage. It serves as the write clock, the read clock and the stage-to-stage transfer clock. This matches the case where the transfer clock is tied to the faster of the two port clocks. Writers see only the first stage's ready flag, and readers see only the last stage's valid flag. Every other stage flag stays inside the chain.

A word written into an empty chain ripples forward one stage per cycle. In the same way, a slot freed by a read from a full chain bubbles backward one stage per cycle. Once data is flowing, words stream through at one per cycle with no extra delay. The total capacity is the number of stages times the stage depth.

Top module: `depth_chain`

## Requirements
- R1: After a synchronous active-low reset, `wr_ready` is 1 and `rd_valid` is 0.
- R2: Words leave at `rd_data` in the order they were accepted. No word is lost or duplicated. While `rd_valid` is 1 and `rd_en` is 0, `rd_valid` and `rd_data` hold.
- R3: With no reads, the chain accepts exactly `STAGES*STAGE_DEPTH` words. After that, `wr_ready` stays 0.
- R4: A word accepted at edge e into an empty chain raises `rd_valid` at edge e+STAGES-1, and that edge is its head word. This is `STAGES` edges counted from the edge after the write request is driven. It is never more than (STAGES-1)*4+3 cycles.
- R5: In a full chain, one read at edge e raises `wr_ready` after edge e+STAGES-1. It is never more than (STAGES-1)*3+2 cycles.
- R6: With writes and reads requested every cycle, `wr_ready` stays 1. Once the first word reaches the output, `rd_valid` stays 1 and one word leaves per cycle.
- R7: A write request while `wr_ready` is 0 is ignored. Its word never appears at the output.
- R8: A read request while `rd_valid` is 0 is ignored. An empty chain keeps `rd_valid` at 0, and a later word is delivered unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for writes, reads and stage transfers |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request; a word is accepted when `wr_ready` is also 1 |
| wr_data | input | WIDTH | Word to write |
| wr_ready | output | 1 | First stage has a free slot |
| rd_en | input | 1 | Read request; the head word is removed when `rd_valid` is also 1 |
| rd_valid | output | 1 | Last stage holds a word |
| rd_data | output | WIDTH | Head word of the chain |

## Verification
The assertions take for granted that a writer never relies on a request being taken while `wr_ready` is 0. They also assume a reader treats `rd_data` as meaningful only while `rd_valid` is 1. The occupancy model counts only handshakes that complete, so it stays within 0 and the capacity under any stimulus. The bench changes requests only on the falling edge, after reading the flags it depends on. It requests writes against a full chain and reads against an empty one on purpose, to show that these requests are ignored.

// File: rtl/chain_pkg.sv
// chain_pkg: shared helpers for the depth chain.
// Assumes: depths are at least 1.
package chain_pkg;

    // Width of an address that indexes DEPTH slots (minimum 1 bit)
    function automatic int unsigned addr_width(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Width of a counter that holds 0..DEPTH
    function automatic int unsigned count_width(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/lane_store.sv
// lane_store: word storage for one stage, one write port and one
// combinational read port.
// Assumes: the caller never writes a slot that is being presented as head.
module lane_store #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned AW    = 2
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] slots [DEPTH];

    // Store the incoming word in its slot
    always_ff @(posedge clk) begin
        if (we) begin
            slots[waddr] <= wdata;
        end
    end

    // Present the addressed word
    assign rdata = slots[raddr];
endmodule

// File: rtl/fifo_stage.sv
// fifo_stage: one fall-through buffer stage. The oldest word is always
// presented with out_valid; out_take removes it. in_ready means a free slot.
// Assumes: in_valid/out_take follow the valid/ready handshake convention.
module fifo_stage
    import chain_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    input  logic             out_take
);
    localparam int unsigned AW = addr_width(DEPTH);
    localparam int unsigned CW = count_width(DEPTH);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

    logic [CW-1:0] fill_q;
    logic [AW-1:0] wptr_q;
    logic [AW-1:0] rptr_q;
    logic          push;
    logic          pop;

    // Handshake results for this cycle
    assign in_ready  = (fill_q != FULL_CNT);
    assign out_valid = (fill_q != '0);
    assign push      = in_valid && in_ready;
    assign pop       = out_take && out_valid;

    // Track occupancy and both wrapping pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (push) begin
                wptr_q <= (wptr_q == LAST_SLOT) ? '0 : wptr_q + 1'b1;
            end
            if (pop) begin
                rptr_q <= (rptr_q == LAST_SLOT) ? '0 : rptr_q + 1'b1;
            end
            if (push && !pop) begin
                fill_q <= fill_q + 1'b1;
            end else if (pop && !push) begin
                fill_q <= fill_q - 1'b1;
            end
        end
    end

    lane_store #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (wptr_q),
        .wdata (in_data),
        .raddr (rptr_q),
        .rdata (out_data)
    );
endmodule

// File: rtl/depth_chain.sv
// depth_chain: STAGES fall-through stages in series, joined only by
// valid/ready links on one common clock. Capacity is STAGES*STAGE_DEPTH.
// Assumes: one clock serves writes, reads and transfers; STAGES >= 1.
module depth_chain #(
    parameter int unsigned WIDTH       = 16,
    parameter int unsigned STAGE_DEPTH = 4,
    parameter int unsigned STAGES      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_ready,
    input  logic             rd_en,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data
);
    // Link k feeds stage k; link STAGES is the chain output
    logic [STAGES:0]  link_valid;
    logic [STAGES:0]  link_ready;
    logic [WIDTH-1:0] link_data [STAGES+1];

    // Attach the external ports to the ends of the chain
    assign link_valid[0]      = wr_en;
    assign link_data[0]       = wr_data;
    assign wr_ready           = link_ready[0];
    assign rd_valid           = link_valid[STAGES];
    assign rd_data            = link_data[STAGES];
    assign link_ready[STAGES] = rd_en;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        fifo_stage #(
            .WIDTH (WIDTH),
            .DEPTH (STAGE_DEPTH)
        ) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (link_valid[s]),
            .in_data   (link_data[s]),
            .in_ready  (link_ready[s]),
            .out_valid (link_valid[s+1]),
            .out_data  (link_data[s+1]),
            .out_take  (link_ready[s+1])
        );
    end
endmodule

// File: rtl/chain_checker.sv
// chain_checker: properties of depth_chain, bound into every instance.
// Assumes: the bound top exposes link_valid/link_ready as in depth_chain.
module chain_checker #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 3,
    parameter int unsigned CAP    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_ready,
    input logic             rd_en,
    input logic             rd_valid,
    input logic [WIDTH-1:0] rd_data,
    input logic [STAGES:0]  link_valid,
    input logic [STAGES:0]  link_ready
);
    localparam int unsigned OW = $clog2(CAP + 1) + 1;
    logic [OW-1:0] occ_q;

    // Count words held, from completed handshakes at the two ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + OW'(wr_en && wr_ready) - OW'(rd_en && rd_valid);
        end
    end

    assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (wr_ready && !rd_valid));

    assert_head_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data)));

    for (genvar k = 1; k <= STAGES; k++) begin : g_link
        assert_link_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (link_valid[k] && !link_ready[k]) |=> link_valid[k]);
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OW'(CAP));

    assert_empty_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0) |-> !rd_valid);
endmodule

bind depth_chain chain_checker #(
    .WIDTH  (WIDTH),
    .STAGES (STAGES),
    .CAP    (STAGES * STAGE_DEPTH)
) u_chain_checker (.*);

// File: tb/test_depth_chain.sv
// Directed bench: a 3-stage chain (i_depth_chain) and a 2-stage chain.
module test_depth_chain;
    localparam int W = 16;
    localparam int SD = 4;
    localparam int NS [2] = '{3, 2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic         wen [2];
    logic [W-1:0] wd  [2];
    logic         ren [2];
    logic         wrdy [2];
    logic         rval [2];
    logic [W-1:0] rd  [2];
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    depth_chain #(.WIDTH(W), .STAGE_DEPTH(SD), .STAGES(3)) i_depth_chain (
        .clk(clk), .rst_n(rst_n), .wr_en(wen[0]), .wr_data(wd[0]),
        .wr_ready(wrdy[0]), .rd_en(ren[0]), .rd_valid(rval[0]), .rd_data(rd[0]));

    depth_chain #(.WIDTH(W), .STAGE_DEPTH(SD), .STAGES(2)) i_depth_chain_n2 (
        .clk(clk), .rst_n(rst_n), .wr_en(wen[1]), .wr_data(wd[1]),
        .wr_ready(wrdy[1]), .rd_en(ren[1]), .rd_valid(rval[1]), .rd_data(rd[1]));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset_r1(input int k);
        rst_n = 1'b0;
        wen[k] = 1'b0; ren[k] = 1'b0; wd[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(wrdy[k] == 1'b1, "R1 wr_ready", int'(wrdy[k]), 1);
        check(rval[k] == 1'b0, "R1 rd_valid", int'(rval[k]), 0);
    endtask

    // First word into empty chain; also reads on empty ignored (R8)
    task automatic t_ripple_r4(input int k);
        int n;
        ren[k] = 1'b1;
        repeat (3) @(negedge clk);
        check(rval[k] == 1'b0, "R8 empty read", int'(rval[k]), 0);
        ren[k] = 1'b0;
        wen[k] = 1'b1; wd[k] = W'(16'h0A00 + k);
        n = 0;
        @(negedge clk);
        wen[k] = 1'b0;
        n = 1;
        while (!rval[k] && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(n == NS[k], "R4 ripple latency", n, NS[k]);
        check(n <= (NS[k] - 1) * 4 + 3, "R4 latency bound", n, (NS[k] - 1) * 4 + 3);
        check(rd[k] == W'(16'h0A00 + k), "R8 word after empty reads", int'(rd[k]), 16'h0A00 + k);
        ren[k] = 1'b1;
        @(negedge clk);
        ren[k] = 1'b0;
        check(rval[k] == 1'b0, "R2 single word removed", int'(rval[k]), 0);
    endtask

    // Fill without reads, probe full writes, bubble a slot, drain in order
    task automatic t_fill_r3(input int k);
        int acc, idle, n, got, exp;
        bit seq_ok;
        acc = 0; idle = 0;
        while (idle < 8) begin
            if (wrdy[k]) begin
                wen[k] = 1'b1; wd[k] = W'(16'h1000 + acc); acc++; idle = 0;
            end else begin
                wen[k] = 1'b0; idle++;
            end
            @(negedge clk);
        end
        check(acc == NS[k] * SD, "R3 capacity", acc, NS[k] * SD);
        wen[k] = 1'b1; wd[k] = 16'hDEAD;
        repeat (3) @(negedge clk);
        wen[k] = 1'b0;
        check(wrdy[k] == 1'b0, "R3 stays full", int'(wrdy[k]), 0);
        check(rd[k] == 16'h1000, "R2 head of full chain", int'(rd[k]), 16'h1000);
        ren[k] = 1'b1;
        @(negedge clk);
        ren[k] = 1'b0;
        n = 1;
        while (!wrdy[k] && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(n == NS[k], "R5 bubble latency", n, NS[k]);
        check(n <= (NS[k] - 1) * 3 + 2, "R5 latency bound", n, (NS[k] - 1) * 3 + 2);
        got = 1; idle = 0; seq_ok = 1;
        ren[k] = 1'b1;
        while (idle < 8) begin
            if (rval[k]) begin
                exp = 16'h1000 + got;
                if (rd[k] != W'(exp)) begin
                    seq_ok = 0;
                    check(0, "R2/R7 drain order", int'(rd[k]), exp);
                end
                got++; idle = 0;
            end else begin
                idle++;
            end
            @(negedge clk);
        end
        ren[k] = 1'b0;
        check(seq_ok, "R2 drain order", int'(seq_ok), 1);
        check(got == NS[k] * SD, "R7 full writes ignored", got, NS[k] * SD);
    endtask

    // Continuous write and read every cycle
    task automatic t_stream_r6(input int k);
        int sent, got, gaps;
        bit started, rdy_ok, ord_ok;
        sent = 0; got = 0; gaps = 0; started = 0; rdy_ok = 1; ord_ok = 1;
        ren[k] = 1'b1;
        for (int c = 0; c < 60 && got < 20; c++) begin
            if (rval[k]) begin
                if (rd[k] != W'(16'h2000 + got)) ord_ok = 0;
                got++; started = 1;
            end else if (started) begin
                gaps++;
            end
            if (sent < 20) begin
                if (!wrdy[k]) rdy_ok = 0;
                wen[k] = 1'b1; wd[k] = W'(16'h2000 + sent);
                if (wrdy[k]) sent++;
            end else begin
                wen[k] = 1'b0;
            end
            @(negedge clk);
        end
        wen[k] = 1'b0; ren[k] = 1'b0;
        check(rdy_ok, "R6 wr_ready held", int'(rdy_ok), 1);
        check(gaps == 0, "R6 no gaps", gaps, 0);
        check(got == 20, "R6 word count", got, 20);
        check(ord_ok, "R2 stream order", int'(ord_ok), 1);
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            wen[i] = 1'b0; ren[i] = 1'b0; wd[i] = '0;
        end
        for (int k = 0; k < 2; k++) begin
            t_reset_r1(k);
            t_ripple_r4(k);
            t_fill_r3(k);
            t_stream_r6(k);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule